// File: doc/BRIEF.md
# In-Order Miss Queue with Non-Blocking Prefetch

This block sits behind a first-level data cache. Loads that missed that cache are queued here along with prefetch requests. The queue works on one entry at a time, always the oldest, and looks it up through a second-level cache port. A load that hits takes its data from the lookup response. A load that misses sends a block request to memory. It then holds the whole queue until the memory fill for its 64-byte block comes back. Later loads wait behind it even when they would hit. This keeps load completion in strict arrival order.

A prefetch entry goes through the same lookup. It retires as soon as the lookup answers, whether the answer was a hit or a miss. A missing prefetch forwards a block request to memory tagged as a prefetch, and the queue moves on at once. A prefetch never returns data. Its block fill lands in the second-level cache, outside this block. The queue holds nine entries and raises `full` when all nine are in use.

The head-of-queue controller has four states. IDLE waits for a non-empty queue. LOOKUP drives the lookup request and waits for its response. MISS_WAIT holds a missing load until its fill arrives. RETIRE presents the retiring entry for one cycle and pops it. The transitions are:
- START: IDLE to LOOKUP, when the queue is non-empty.
- HIT_OR_PF: LOOKUP to RETIRE, on a load hit or on any prefetch response.
- RACE_FILL: LOOKUP to RETIRE, on a load miss that arrives together with a fill for the same block.
- LOAD_MISS: LOOKUP to MISS_WAIT.
- FILL: MISS_WAIT to RETIRE, on a fill for the head's block.
- NEXT: RETIRE to LOOKUP, when more entries wait behind the head.
- DRAIN: RETIRE to IDLE, when no entries wait behind the head.

Top module: `miss_order_queue`

## Requirements
- R1: While reset is asserted and at the first edge after reset, `full`, `retire_valid`, `ld_valid`, `l2_req_valid` and `mem_req_valid` are all low.
- R2: Entries retire in the exact order in which they were accepted. `l2_req_addr` always carries the oldest unretired entry, and no retire occurs with nothing queued.
- R3: While a load waits for its fill, no entry retires, including later loads that would hit.
- R4: A prefetch (`enq_pf`=1) retires in the cycle after its lookup response (`l2_rsp_valid`=1), whether `l2_rsp_hit` is 1 (hit) or 0 (miss).
- R5: A retiring prefetch never raises `ld_valid`. `ld_valid` is raised only together with the retire of a load.
- R6: A prefetch whose lookup misses raises `mem_req_valid` with `mem_req_pf`=1 in the cycle after the response. `mem_req_addr` is its address with the low six bits (byte within the 64-byte block) cleared.
- R7: A load whose lookup misses, with no same-block fill in that cycle, raises `mem_req_valid` with `mem_req_pf`=0 and the block-aligned address in the cycle after the response.
- R8: A waiting load resumes when `fill_valid` is high and `fill_blk` equals its address bits [AW-1:6]. It retires with `ld_valid` and `ld_data`=`fill_data` in the next cycle. Fills for other blocks are ignored.
- R9: If a same-block fill arrives in the same cycle as a load's miss response, the load completes from that fill in the next cycle and no memory request is sent.
- R10: A load whose lookup hits retires in the next cycle with `ld_data` equal to the `l2_rsp_data` of the response.
- R11: `full` is high exactly when nine entries are held. An enqueue offered while `full` is high is dropped and never retires.
- R12: An enqueue accepted in the same cycle as a retire leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a new entry |
| enq_addr | input | AW | Byte address of the entry |
| enq_pf | input | 1 | 1 = prefetch, 0 = load |
| full | output | 1 | Nine entries held |
| l2_req_valid | output | 1 | Lookup request for the head entry |
| l2_req_addr | output | AW | Address looked up |
| l2_rsp_valid | input | 1 | Lookup response present |
| l2_rsp_hit | input | 1 | 1 = hit, 0 = miss |
| l2_rsp_data | input | DW | Load data on a hit |
| mem_req_valid | output | 1 | One-cycle block request to memory |
| mem_req_addr | output | AW | Block-aligned request address |
| mem_req_pf | output | 1 | Request came from a prefetch |
| fill_valid | input | 1 | Memory fill returning |
| fill_blk | input | AW-6 | Block number of the fill |
| fill_data | input | DW | Data word for the waiting load |
| ld_valid | output | 1 | Load data returned |
| ld_data | output | DW | Returned load data |
| retire_valid | output | 1 | Head entry retires this cycle |
| retire_pf | output | 1 | Retiring entry is a prefetch |
| retire_addr | output | AW | Address of the retiring entry |

## Verification
A wrong queue pointer shows up as a wrong `l2_req_addr` at the very next lookup, and as a mismatched `retire_addr` one or two cycles later. A wrong occupancy count disagrees with `full` at the next enqueue offered near capacity. A wrong controller state shows within one cycle of a lookup response or a fill. The possible symptoms are a retire during a miss wait, a missing retire after a prefetch response, a missing or extra memory request, or load data that is not the hit data or the fill word. The bench tracks occupancy, second-level residency and memory latency itself. From that model it predicts, for each lookup response, the exact next cycle's retire, request and data.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Head-of-queue controller states
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_WAIT   = 2'd2,
        S_RETIRE = 2'd3
    } head_state_e;

    // Byte offset bits inside one 64-byte block
    localparam int BLK_OFF_W = 6;

endpackage

// File: rtl/mq_store.sv
module mq_store #(
    parameter int DEPTH = 9,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          push_pf,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic          head_pf,
    output logic          empty,
    output logic          full,
    output logic          more
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] slot_addr [DEPTH];
    logic          slot_pf   [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok;

    assign push_ok = push && !full;

    // Entry storage: no reset needed, validity tracked by count
    always_ff @(posedge clk) begin
        if (push_ok) begin
            slot_addr[wr_ptr] <= push_addr;
            slot_pf[wr_ptr]   <= push_pf;
        end
    end

    // Pointers wrap at DEPTH, which need not be a power of two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push_ok, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_addr = slot_addr[rd_ptr];
    assign head_pf   = slot_pf[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign more      = (count > CW'(1));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r11_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));
    a_r12_swap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop) |=> $stable(count));
    a_r2_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mq_head_fsm.sv
module mq_head_fsm
    import mq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 64,
    parameter int OFFW = BLK_OFF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           q_empty,
    input  logic           q_more,
    input  logic [AW-1:0]  head_addr,
    input  logic           head_pf,
    input  logic           l2_rsp_valid,
    input  logic           l2_rsp_hit,
    input  logic [DW-1:0]  l2_rsp_data,
    input  logic           fill_valid,
    input  logic [AW-OFFW-1:0] fill_blk,
    input  logic [DW-1:0]  fill_data,
    output logic           pop,
    output logic           l2_req_valid,
    output logic [AW-1:0]  l2_req_addr,
    output logic           mem_req_valid,
    output logic [AW-1:0]  mem_req_addr,
    output logic           mem_req_pf,
    output logic           ld_valid,
    output logic [DW-1:0]  ld_data,
    output logic           retire_valid,
    output logic           retire_pf,
    output logic [AW-1:0]  retire_addr
);
    head_state_e state, nxt;

    logic          fill_match;
    logic          answered;
    logic          miss_to_mem;
    logic [DW-1:0] data_q;
    logic          mreq_q, mreq_pf_q;
    logic [AW-1:0] mreq_addr_q;

    assign fill_match  = fill_valid && (fill_blk == head_addr[AW-1:OFFW]);
    assign answered    = (state == S_LOOKUP) && l2_rsp_valid;
    // prefetch misses always go out; a load miss is satisfied by a racing fill
    assign miss_to_mem = answered && !l2_rsp_hit && (head_pf || !fill_match);

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = q_empty ? S_IDLE : S_LOOKUP;                  // START
            S_LOOKUP: begin
                if (!l2_rsp_valid)                           nxt = S_LOOKUP;
                else if (head_pf || l2_rsp_hit || fill_match) nxt = S_RETIRE; // HIT_OR_PF / RACE_FILL
                else                                         nxt = S_WAIT;   // LOAD_MISS
            end
            S_WAIT:   nxt = fill_match ? S_RETIRE : S_WAIT;               // FILL
            S_RETIRE: nxt = q_more ? S_LOOKUP : S_IDLE;                   // NEXT / DRAIN
            default:  nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Load data capture from a hit response or from the block fill
    always_ff @(posedge clk) begin
        if (answered && !head_pf) begin
            data_q <= l2_rsp_hit ? l2_rsp_data : fill_data;
        end else if ((state == S_WAIT) && fill_match) begin
            data_q <= fill_data;
        end
    end

    // Memory request: one registered pulse per miss sent out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_q      <= 1'b0;
            mreq_pf_q   <= 1'b0;
            mreq_addr_q <= '0;
        end else begin
            mreq_q <= miss_to_mem;
            if (miss_to_mem) begin
                mreq_pf_q   <= head_pf;
                mreq_addr_q <= {head_addr[AW-1:OFFW], {OFFW{1'b0}}};
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        l2_req_valid  = 1'b0;
        retire_valid  = 1'b0;
        retire_pf     = 1'b0;
        ld_valid      = 1'b0;
        pop           = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_LOOKUP: l2_req_valid = 1'b1;
            S_WAIT:   ;
            S_RETIRE: begin
                retire_valid = 1'b1;
                retire_pf    = head_pf;
                ld_valid     = !head_pf;
                pop          = 1'b1;
            end
            default:  ;
        endcase
        l2_req_addr   = head_addr;
        retire_addr   = head_addr;
        ld_data       = data_q;
        mem_req_valid = mreq_q;
        mem_req_pf    = mreq_pf_q;
        mem_req_addr  = mreq_addr_q;
    end

    a_r4_pf_retires_next: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && head_pf) |=> (retire_valid && retire_pf));
    a_r6_pf_miss_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && head_pf && !l2_rsp_hit) |=> (mem_req_valid && mem_req_pf));
    a_r7_load_miss_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && !head_pf && !l2_rsp_hit && !fill_match) |=> (mem_req_valid && !mem_req_pf));
    a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && !fill_match) |=> !retire_valid);
    a_r8_fill_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && fill_match) |=> (ld_valid && ld_data == $past(fill_data)));
    a_r9_race_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && !head_pf && !l2_rsp_hit && fill_match) |=> (ld_valid && !mem_req_valid));
    a_r10_hit_data: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && !head_pf && l2_rsp_hit) |=> (ld_valid && ld_data == $past(l2_rsp_data)));
    a_r5_pf_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        retire_pf |-> !ld_valid);

endmodule

// File: rtl/miss_order_queue.sv
module miss_order_queue
    import mq_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int AW    = 16,
    parameter int DW    = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enq_valid,
    input  logic [AW-1:0]           enq_addr,
    input  logic                    enq_pf,
    output logic                    full,
    output logic                    l2_req_valid,
    output logic [AW-1:0]           l2_req_addr,
    input  logic                    l2_rsp_valid,
    input  logic                    l2_rsp_hit,
    input  logic [DW-1:0]           l2_rsp_data,
    output logic                    mem_req_valid,
    output logic [AW-1:0]           mem_req_addr,
    output logic                    mem_req_pf,
    input  logic                    fill_valid,
    input  logic [AW-BLK_OFF_W-1:0] fill_blk,
    input  logic [DW-1:0]           fill_data,
    output logic                    ld_valid,
    output logic [DW-1:0]           ld_data,
    output logic                    retire_valid,
    output logic                    retire_pf,
    output logic [AW-1:0]           retire_addr
);
    logic [AW-1:0] head_addr;
    logic          head_pf;
    logic          q_empty, q_more, pop;

    mq_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_valid),
        .push_addr (enq_addr),
        .push_pf   (enq_pf),
        .pop       (pop),
        .head_addr (head_addr),
        .head_pf   (head_pf),
        .empty     (q_empty),
        .full      (full),
        .more      (q_more)
    );

    mq_head_fsm #(
        .AW   (AW),
        .DW   (DW),
        .OFFW (BLK_OFF_W)
    ) u_head (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_empty       (q_empty),
        .q_more        (q_more),
        .head_addr     (head_addr),
        .head_pf       (head_pf),
        .l2_rsp_valid  (l2_rsp_valid),
        .l2_rsp_hit    (l2_rsp_hit),
        .l2_rsp_data   (l2_rsp_data),
        .fill_valid    (fill_valid),
        .fill_blk      (fill_blk),
        .fill_data     (fill_data),
        .pop           (pop),
        .l2_req_valid  (l2_req_valid),
        .l2_req_addr   (l2_req_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_pf    (mem_req_pf),
        .ld_valid      (ld_valid),
        .ld_data       (ld_data),
        .retire_valid  (retire_valid),
        .retire_pf     (retire_pf),
        .retire_addr   (retire_addr)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!full && !retire_valid && !mem_req_valid));

endmodule

// File: tb/miss_order_queue_bench.sv
module miss_order_queue_bench;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int BW = AW - 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          enq_valid = 0, enq_pf = 0;
    logic [AW-1:0] enq_addr = '0;
    logic          full;
    logic          l2_req_valid;
    logic [AW-1:0] l2_req_addr;
    logic          l2_rsp_valid = 0, l2_rsp_hit = 0;
    logic [DW-1:0] l2_rsp_data = '0;
    logic          mem_req_valid, mem_req_pf;
    logic [AW-1:0] mem_req_addr;
    logic          fill_valid = 0;
    logic [BW-1:0] fill_blk = '0;
    logic [DW-1:0] fill_data = '0;
    logic          ld_valid, retire_valid, retire_pf;
    logic [DW-1:0] ld_data;
    logic [AW-1:0] retire_addr;

    miss_order_queue u_miss_order_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_pf(enq_pf), .full(full),
        .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr),
        .l2_rsp_valid(l2_rsp_valid), .l2_rsp_hit(l2_rsp_hit), .l2_rsp_data(l2_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
        .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
        .ld_valid(ld_valid), .ld_data(ld_data),
        .retire_valid(retire_valid), .retire_pf(retire_pf), .retire_addr(retire_addr)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] hit_word(input logic [AW-1:0] a);
        return {a, ~a, a ^ 16'h5A5A, a + 16'h1111};
    endfunction

    function automatic logic [DW-1:0] fill_word(input logic [BW-1:0] b);
        return {b, 6'h2A, ~b, 6'h15, b ^ 10'h155, 6'h3F, 16'hC0DE};
    endfunction

    // Expected queue contents in acceptance order
    logic [AW-1:0] e_addr [1024];
    bit            e_pf   [1024];
    bit            e_hit  [1024];
    int            wr_i = 0;
    int            rd_i = 0;

    // Second-level residency and outstanding memory requests
    bit  res   [1024];
    bit  p_v   [32];
    int  p_blk [32];
    int  p_cnt [32];
    int  budget = -1;
    bit  race_mode = 0;

    // Model state between negedges
    int            kind = 0;
    logic [BW-1:0] kind_blk = '0;
    bit            wait_v = 0;
    logic [BW-1:0] wait_blk = '0;
    bit            prev_fill = 0;
    logic [BW-1:0] prev_blk = '0;

    function automatic bit any_pending();
        for (int i = 0; i < 32; i++) if (p_v[i]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) res[i] = (i % 2 == 0);
        for (int i = 0; i < 32; i++) p_v[i] = 0;
    end

    // Second-level cache, memory and scoreboard model, acting on every negedge
    always @(negedge clk) begin : model
        int fi;
        logic [BW-1:0] b;
        bit hit;
        if (rst_n) begin
            // blocked load: resumes only the cycle after its own block's fill
            if (wait_v) begin
                if (prev_fill && prev_blk == wait_blk) begin
                    chk(ld_valid, "R8 fill resumes waiting load", 64'(ld_valid), 64'd1);
                    wait_v = 0;
                end else begin
                    chk(!retire_valid, "R3 nothing retires during miss wait", 64'(retire_valid), 64'd0);
                end
            end
            // outcome of the previous lookup response
            case (kind)
                1: chk(retire_valid && ld_valid, "R10 load hit retires next cycle", 64'(retire_valid), 64'd1);
                5: chk(retire_valid && retire_pf && !mem_req_valid, "R4 prefetch hit retires next cycle",
                       64'({retire_valid, retire_pf, mem_req_valid}), 64'b110);
                3: begin
                    chk(retire_valid && retire_pf, "R4 prefetch miss retires next cycle",
                        64'({retire_valid, retire_pf}), 64'b11);
                    chk(mem_req_valid && mem_req_pf && mem_req_addr == {kind_blk, 6'd0},
                        "R6 prefetch miss forwarded", 64'(mem_req_addr), 64'({kind_blk, 6'd0}));
                end
                2: begin
                    chk(!retire_valid, "R3 load miss blocks", 64'(retire_valid), 64'd0);
                    chk(mem_req_valid && !mem_req_pf && mem_req_addr == {kind_blk, 6'd0},
                        "R7 load miss request", 64'(mem_req_addr), 64'({kind_blk, 6'd0}));
                    wait_v = 1;
                    wait_blk = kind_blk;
                end
                4: chk(retire_valid && ld_valid && !mem_req_valid, "R9 racing fill completes load",
                       64'({retire_valid, ld_valid, mem_req_valid}), 64'b110);
                default: ;
            endcase
            // retire order and returned data
            if (retire_valid) begin
                chk(rd_i < wr_i, "R11 retire of an entry never accepted", 64'(rd_i), 64'(wr_i));
                chk(retire_addr == e_addr[rd_i] && retire_pf == e_pf[rd_i], "R2 retire order",
                    64'({retire_pf, retire_addr}), 64'({e_pf[rd_i], e_addr[rd_i]}));
                if (e_pf[rd_i]) begin
                    chk(!ld_valid, "R5 prefetch returns no data", 64'(ld_valid), 64'd0);
                end else begin
                    logic [DW-1:0] ex;
                    ex = e_hit[rd_i] ? hit_word(e_addr[rd_i]) : fill_word(e_addr[rd_i][AW-1:6]);
                    chk(ld_valid && ld_data == ex, "R10 R8 load data", ld_data, ex);
                end
                rd_i++;
            end else begin
                chk(!ld_valid, "R5 data only with a load retire", 64'(ld_valid), 64'd0);
            end
            // memory: take new requests
            if (mem_req_valid) begin
                fi = -1;
                for (int i = 0; i < 32; i++) if (!p_v[i] && fi < 0) fi = i;
                if (fi >= 0) begin
                    p_v[fi] = 1;
                    p_blk[fi] = int'(mem_req_addr[AW-1:6]);
                    p_cnt[fi] = 2 + 3 * int'(mem_req_addr[7:6]);
                end
            end
            // memory: age requests and pick at most one fill
            fi = -1;
            for (int i = 0; i < 32; i++) begin
                if (p_v[i] && p_cnt[i] > 0) p_cnt[i]--;
                else if (p_v[i] && fi < 0) fi = i;
            end
            fill_valid = 0;
            // lookup response
            kind = 0;
            l2_rsp_valid = 0;
            if (l2_req_valid && budget != 0) begin
                b = l2_req_addr[AW-1:6];
                chk(l2_req_addr == e_addr[rd_i], "R2 lookup targets oldest entry",
                    64'(l2_req_addr), 64'(e_addr[rd_i]));
                hit = res[b];
                l2_rsp_valid = 1;
                l2_rsp_hit = hit;
                l2_rsp_data = hit ? hit_word(l2_req_addr) : ~hit_word(l2_req_addr);
                e_hit[rd_i] = hit;
                if (budget > 0) budget--;
                kind_blk = b;
                if (e_pf[rd_i]) begin
                    kind = hit ? 5 : 3;
                end else if (hit) begin
                    kind = 1;
                end else if (race_mode || (fi >= 0 && p_blk[fi] == int'(b))) begin
                    kind = 4;
                    if (race_mode && !(fi >= 0 && p_blk[fi] == int'(b))) begin
                        fi = -1;
                        fill_valid = 1;
                        fill_blk = b;
                        fill_data = fill_word(b);
                        res[b] = 1;
                    end
                    race_mode = 0;
                end else begin
                    kind = 2;
                end
            end
            if (fi >= 0) begin
                p_v[fi] = 0;
                fill_valid = 1;
                fill_blk = BW'(p_blk[fi]);
                fill_data = fill_word(BW'(p_blk[fi]));
                res[p_blk[fi]] = 1;
            end
            prev_fill = fill_valid;
            prev_blk = fill_blk;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Offer one entry; occupancy seen by the bench must agree with full
    task automatic enq(input logic [AW-1:0] a, input bit pf);
        int occ;
        occ = wr_i - rd_i + int'(retire_valid);
        chk(full == (occ == 9), "R11 full tracks nine held", 64'(full), 64'(occ == 9));
        enq_valid = 1;
        enq_addr = a;
        enq_pf = pf;
        if (!full) begin
            e_addr[wr_i] = a;
            e_pf[wr_i] = pf;
            wr_i++;
        end
        tick();
        enq_valid = 0;
    endtask

    task automatic drain();
        while (rd_i != wr_i || wait_v || any_pending() || kind != 0) tick();
        repeat (3) tick();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
        finish_run();
    end

    initial begin : stim
        logic [15:0] lf;
        lf = 16'hACE1;
        tick();
        chk(!full && !retire_valid && !ld_valid && !l2_req_valid && !mem_req_valid, "R1 quiet in reset",
            64'({full, retire_valid, ld_valid, l2_req_valid, mem_req_valid}), 64'd0);
        repeat (2) tick();
        rst_n = 1;
        tick();
        chk(!full && !retire_valid && !ld_valid && !l2_req_valid && !mem_req_valid, "R1 quiet after reset",
            64'({full, retire_valid, ld_valid, l2_req_valid, mem_req_valid}), 64'd0);

        // Sweep: mixes of loads and prefetches, burst gaps, shifting residency
        for (int p = 0; p < 40; p++) begin
            for (int bb = 0; bb < 16; bb++) res[bb] = ((bb + p) % 3 == 0);
            for (int k = 0; k < 10; k++) begin
                bit pf;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                pf = (p % 4 == 0) ? 1'b0 : (p % 4 == 1) ? 1'b1 : lf[10];
                enq({6'd0, lf[3:0], lf[9:4]}, pf);
                if (p % 3 != 0) repeat (int'(lf[12:11])) tick();
            end
        end
        drain();

        // R11: stall lookups, fill nine, offer a tenth that must be dropped
        for (int bb = 0; bb < 16; bb++) res[bb] = 1;
        budget = 0;
        for (int k = 0; k < 9; k++) enq({6'd0, 4'd2, 6'(k)}, 1'b0);
        chk(full, "R11 full at nine", 64'(full), 64'd1);
        enq(16'h03FF, 1'b0);
        chk(full, "R11 still full after dropped offer", 64'(full), 64'd1);
        budget = -1;
        drain();
        chk(rd_i == wr_i, "R11 dropped entry never retires", 64'(rd_i), 64'(wr_i));

        // R12: enqueue in the retire cycle keeps occupancy at eight
        budget = 0;
        for (int k = 0; k < 8; k++) enq({6'd0, 4'd4, 6'(k)}, 1'b1);
        budget = 1;
        tick();
        while (!retire_valid) tick();
        enq({6'd0, 4'd6, 6'd1}, 1'b0);
        chk(!full, "R12 swap leaves eight held", 64'(full), 64'd0);
        enq({6'd0, 4'd6, 6'd2}, 1'b0);
        chk(full, "R12 one more reaches nine", 64'(full), 64'd1);
        budget = -1;
        drain();

        // R8 and R3: prefetch fill for another block arrives during a load wait,
        // and a hitting load behind the waiting one stays blocked
        res[1] = 0; res[3] = 0; res[4] = 1;
        enq({6'd0, 4'd1, 6'd8}, 1'b1);
        enq({6'd0, 4'd3, 6'd9}, 1'b0);
        enq({6'd0, 4'd4, 6'd10}, 1'b0);
        drain();

        // R9: fill for the same block races the load's miss response
        res[5] = 0;
        race_mode = 1;
        enq({6'd0, 4'd5, 6'd12}, 1'b0);
        drain();

        chk(rd_i == wr_i, "R2 every accepted entry retired", 64'(rd_i), 64'(wr_i));
        finish_run();
    end

endmodule